// File: doc/BRIEF.md
# Background Block-Store Engine

This block holds a small pool of buffers. Each buffer runs one block-fill operation in the background: it writes the same data word to a run of consecutive memory words while the rest of the core carries on issuing and completing instructions. An operation is started on the command port with a start address, a word count and a fill value. In the same cycle the engine returns a handle, which is the index of the buffer it took. After that the engine keeps its own copy of all three operands, so the source registers can be released at once.

The engine shares one memory write port with the main memory unit. It offers a store only in cycles when that unit reports that it is idle. A store counts as issued only when write-valid and accept are high in the same cycle. When more than one buffer is running, a round-robin arbiter chooses which buffer gets each idle slot.

Software uses the handle for two things. It can read the buffer's state and the number of words stored so far. It can also cancel the operation. A finished or cancelled buffer stays in its final state until a status read collects the result, and only then is the buffer returned to the pool.

Top module: `bgstore_engine`

## Requirements
- R1: After reset every buffer reads as free, `cmd_ready` is high and `mem_wvalid` is low.
- R2: `cmd_ready` is high exactly when at least one buffer is free. On an accepted command, `cmd_handle` gives the lowest-numbered free buffer. When all four buffers are in use, commands are refused.
- R3: `mem_wvalid` is never high in a cycle where `mem_busy` is high. Whenever `mem_busy` is low and some buffer is running without being cancelled in that cycle, `mem_wvalid` is high.
- R4: A buffer's k-th issued store (k counted from 0) places its captured fill value at byte address start + 8·k. A store is issued only on a cycle where `mem_wvalid` and `mem_wready` are both high. An offered store that is not accepted does not advance the buffer.
- R5: A buffer turns done on the edge that issues its last store. A command with a count of 0 goes straight to done and never stores.
- R6: Among buffers that are requesting, the grant goes to the first index after the last buffer that had a store issued, wrapping around. The first grant after reset goes to index 0 when index 0 is requesting.
- R7: A status read answers in the same cycle. It returns the code for the handle (00 free, 01 running, 10 done, 11 cancelled) and the number of words stored so far.
- R8: A status read of a done or cancelled buffer frees that buffer at the next edge. A status read of a free or running buffer changes nothing.
- R9: Cancelling a running buffer masks its request in the cancel cycle and moves it to cancelled, so it issues no further stores. Cancelling a buffer that is not running has no effect on it.
- R10: Operands are captured at issue. The low three address bits are cleared, and later changes on the command inputs do not affect stores already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | New fill operation offered |
| cmd_ready | output | 1 | A buffer is free to take a command |
| cmd_addr | input | 32 | Start byte address |
| cmd_count | input | 16 | Number of 64-bit words to store |
| cmd_data | input | 64 | Fill value |
| cmd_handle | output | 2 | Buffer index taken by this command |
| qry_valid | input | 1 | Status read request |
| qry_handle | input | 2 | Buffer to read |
| qry_status | output | 2 | State code of that buffer |
| qry_words | output | 16 | Words stored so far |
| cxl_valid | input | 1 | Cancel request |
| cxl_handle | input | 2 | Buffer to cancel |
| mem_busy | input | 1 | Main memory unit is using the port |
| mem_wvalid | output | 1 | Store offered |
| mem_waddr | output | 32 | Store byte address |
| mem_wdata | output | 64 | Store data |
| mem_wready | input | 1 | Port accepts the offered store |

## Verification
A buffer that holds a wrong address, count or state shows up at the memory port. The bad store appears in the very cycle the buffer is next granted: the address is wrong, the data is wrong, or the store is extra or missing. The status port shows the error in the same cycle it is read, as a wrong code or a wrong word count. A wrong arbiter pointer shows on the next idle cycle with two or more buffers requesting, because the address then belongs to the wrong buffer. A buffer that is never freed shows as `cmd_ready` staying low, or as the wrong handle on the next command.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
   typedef enum logic [1:0] {
      ST_FREE = 2'b00,
      ST_RUN  = 2'b01,
      ST_DONE = 2'b10,
      ST_CXL  = 2'b11
   } bgs_state_e;
endpackage

// File: rtl/bgs_slot.sv
module bgs_slot
   import bgs_pkg::*;
#(
   parameter int AW  = 32,
   parameter int DW  = 64,
   parameter int CW  = 16,
   parameter int LSB = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] ld_addr_i,
   input  logic [CW-1:0] ld_count_i,
   input  logic [DW-1:0] ld_data_i,
   input  logic          cancel_i,
   input  logic          fire_i,
   input  logic          release_i,
   output bgs_state_e    state_o,
   output logic          req_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] data_o,
   output logic [CW-1:0] words_o
);
   localparam logic [AW-1:0] STEP = AW'(DW / 8);

   bgs_state_e    state_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic [CW-1:0] remain_q;
   logic [CW-1:0] words_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_FREE;
         addr_q   <= '0;
         data_q   <= '0;
         remain_q <= '0;
         words_q  <= '0;
      end else if (load_i) begin
         addr_q   <= {ld_addr_i[AW-1:LSB], {LSB{1'b0}}};
         data_q   <= ld_data_i;
         remain_q <= ld_count_i;
         words_q  <= '0;
         state_q  <= (ld_count_i == '0) ? ST_DONE : ST_RUN;
      end else begin
         if (fire_i) begin
            addr_q   <= addr_q + STEP;
            remain_q <= remain_q - CW'(1);
            words_q  <= words_q + CW'(1);
         end
         if (state_q == ST_RUN && cancel_i)
            state_q <= ST_CXL;
         else if (state_q == ST_RUN && fire_i && remain_q == CW'(1))
            state_q <= ST_DONE;
         else if ((state_q == ST_DONE || state_q == ST_CXL) && release_i)
            state_q <= ST_FREE;
      end
   end

   assign state_o = state_q;
   assign req_o   = (state_q == ST_RUN) && !cancel_i;
   assign addr_o  = addr_q;
   assign data_o  = data_q;
   assign words_o = words_q;
endmodule

// File: rtl/bgs_alloc.sv
module bgs_alloc #(
   parameter int N  = 4,
   localparam int HW = $clog2(N)
) (
   input  logic [N-1:0]  free_i,
   output logic          any_o,
   output logic [HW-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--)
         if (free_i[i]) idx_o = HW'(i);
   end
   assign any_o = |free_i;
endmodule

// File: rtl/bgs_arb.sv
module bgs_arb #(
   parameter int N   = 4,
   parameter bit RR  = 1'b1,
   localparam int HW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   input  logic          advance_i,
   output logic [N-1:0]  gnt_o,
   output logic [HW-1:0] gnt_idx_o
);
   generate
      if (RR) begin : g_rr
         logic [HW-1:0] last_q;
         always_comb begin
            gnt_idx_o = '0;
            for (int k = N; k >= 1; k--) begin
               if (req_i[(int'(last_q) + k) % N])
                  gnt_idx_o = HW'((int'(last_q) + k) % N);
            end
         end
         always_ff @(posedge clk) begin
            if (!rst_n)         last_q <= HW'(N - 1);
            else if (advance_i) last_q <= gnt_idx_o;
         end
      end else begin : g_fixed
         always_comb begin
            gnt_idx_o = '0;
            for (int i = N - 1; i >= 0; i--)
               if (req_i[i]) gnt_idx_o = HW'(i);
         end
      end
   endgenerate

   always_comb begin
      gnt_o = '0;
      if (|req_i) gnt_o[gnt_idx_o] = 1'b1;
   end
endmodule

// File: rtl/bgstore_engine.sv
module bgstore_engine
   import bgs_pkg::*;
#(
   parameter int NBUF = 4,
   parameter int AW   = 32,
   parameter int DW   = 64,
   parameter int CW   = 16,
   parameter bit RR   = 1'b1,
   localparam int HW  = $clog2(NBUF),
   localparam int LSB = $clog2(DW / 8)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic [AW-1:0] cmd_addr,
   input  logic [CW-1:0] cmd_count,
   input  logic [DW-1:0] cmd_data,
   output logic [HW-1:0] cmd_handle,
   input  logic          qry_valid,
   input  logic [HW-1:0] qry_handle,
   output logic [1:0]    qry_status,
   output logic [CW-1:0] qry_words,
   input  logic          cxl_valid,
   input  logic [HW-1:0] cxl_handle,
   input  logic          mem_busy,
   output logic          mem_wvalid,
   output logic [AW-1:0] mem_waddr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_wready
);
   if (NBUF < 2 || (1 << HW) != NBUF)
      $error("NBUF must be a power of two, at least 2");
   if (DW < 8 || (DW % 8) != 0 || (1 << LSB) * 8 != DW)
      $error("DW must be a power-of-two number of bytes");
   if (CW < 1 || AW <= LSB)
      $error("CW and AW too small");

   bgs_state_e    s_state [NBUF];
   logic [AW-1:0] s_addr  [NBUF];
   logic [DW-1:0] s_data  [NBUF];
   logic [CW-1:0] s_words [NBUF];
   logic [NBUF-1:0] s_req, s_free, s_load, s_fire, s_cxl, s_rel;
   logic [NBUF-1:0] arb_gnt;
   logic [HW-1:0]   arb_idx;
   logic [2*NBUF-1:0] st_flat;
   logic            accept, store_go;

   bgs_alloc #(.N(NBUF)) u_alloc (
      .free_i (s_free),
      .any_o  (cmd_ready),
      .idx_o  (cmd_handle)
   );

   assign accept   = cmd_valid && cmd_ready;
   assign store_go = mem_wvalid && mem_wready;

   bgs_arb #(.N(NBUF), .RR(RR)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (s_req),
      .advance_i (store_go),
      .gnt_o     (arb_gnt),
      .gnt_idx_o (arb_idx)
   );

   for (genvar g = 0; g < NBUF; g++) begin : g_slot
      assign s_load[g] = accept && (cmd_handle == HW'(g));
      assign s_cxl[g]  = cxl_valid && (cxl_handle == HW'(g));
      assign s_rel[g]  = qry_valid && (qry_handle == HW'(g));
      assign s_fire[g] = store_go && arb_gnt[g];
      assign s_free[g] = (s_state[g] == ST_FREE);
      assign st_flat[2*g +: 2] = s_state[g];

      bgs_slot #(.AW(AW), .DW(DW), .CW(CW), .LSB(LSB)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_i     (s_load[g]),
         .ld_addr_i  (cmd_addr),
         .ld_count_i (cmd_count),
         .ld_data_i  (cmd_data),
         .cancel_i   (s_cxl[g]),
         .fire_i     (s_fire[g]),
         .release_i  (s_rel[g]),
         .state_o    (s_state[g]),
         .req_o      (s_req[g]),
         .addr_o     (s_addr[g]),
         .data_o     (s_data[g]),
         .words_o    (s_words[g])
      );
   end

   assign mem_wvalid = (|s_req) && !mem_busy;
   assign mem_waddr  = s_addr[arb_idx];
   assign mem_wdata  = s_data[arb_idx];
   assign qry_status = s_state[qry_handle];
   assign qry_words  = s_words[qry_handle];
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker
   import bgs_pkg::*;
#(
   parameter int NBUF = 4,
   parameter int AW   = 32,
   localparam int HW  = $clog2(NBUF)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mem_busy,
   input logic            mem_wvalid,
   input logic [AW-1:0]   mem_waddr,
   input logic            cmd_ready,
   input logic            cxl_valid,
   input logic [HW-1:0]   cxl_handle,
   input logic            qry_valid,
   input logic [HW-1:0]   qry_handle,
   input logic [1:0]      qry_status,
   input logic [2*NBUF-1:0] st_flat,
   input logic [NBUF-1:0] gnt
);
   logic any_free;
   always_comb begin
      any_free = 1'b0;
      for (int i = 0; i < NBUF; i++)
         if (st_flat[2*i +: 2] == ST_FREE) any_free = 1'b1;
   end

   p_idle_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_busy |-> !mem_wvalid);

   p_ready_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> any_free);

   p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wvalid |-> (mem_waddr[2:0] == 3'b000));

   p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   p_cancel_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cxl_valid && st_flat[2*cxl_handle +: 2] == ST_RUN)
      |=> (st_flat[2*$past(cxl_handle) +: 2] == ST_CXL));

   p_read_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_valid && qry_status == ST_DONE && !(cxl_valid && cxl_handle == qry_handle))
      |=> (st_flat[2*$past(qry_handle) +: 2] == ST_FREE));
endmodule

bind bgstore_engine bgs_checker #(.NBUF(NBUF), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_busy   (mem_busy),
   .mem_wvalid (mem_wvalid),
   .mem_waddr  (mem_waddr),
   .cmd_ready  (cmd_ready),
   .cxl_valid  (cxl_valid),
   .cxl_handle (cxl_handle),
   .qry_valid  (qry_valid),
   .qry_handle (qry_handle),
   .qry_status (qry_status),
   .st_flat    (st_flat),
   .gnt        (arb_gnt)
);

// File: tb/tb_bgstore_engine.sv
`timescale 1ns/1ps
module tb_bgstore_engine;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 0, cmd_ready;
   logic [31:0] cmd_addr = 0;
   logic [15:0] cmd_count = 0;
   logic [63:0] cmd_data = 0;
   logic [1:0]  cmd_handle;
   logic        qry_valid = 0;
   logic [1:0]  qry_handle = 0, qry_status;
   logic [15:0] qry_words;
   logic        cxl_valid = 0;
   logic [1:0]  cxl_handle = 0;
   logic        mem_busy = 0, mem_wvalid, mem_wready = 0;
   logic [31:0] mem_waddr;
   logic [63:0] mem_wdata;

   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   bgstore_engine dut (.*);

   // bench model
   logic [1:0]  ms [N];
   logic [31:0] ma [N];
   logic [63:0] md [N];
   logic [15:0] mr [N];
   logic [15:0] mw [N];
   int          mlast;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int lowest_free();
      for (int i = 0; i < N; i++) if (ms[i] == 2'b00) return i;
      return -1;
   endfunction

   function automatic int rr_pick(input logic [N-1:0] rq);
      for (int k = 1; k <= N; k++) if (rq[(mlast + k) % N]) return (mlast + k) % N;
      return -1;
   endfunction

   // one cycle: inputs already driven after negedge; check then update model
   task automatic cycle();
      logic [N-1:0] rq;
      int lf, gi;
      bit acc, fire;
      #1;
      lf = lowest_free();
      chk(cmd_ready == (lf >= 0), "R2 ready", cmd_ready, lf >= 0);
      acc = cmd_valid && (lf >= 0);
      if (acc) chk(cmd_handle == lf[1:0], "R2 handle", cmd_handle, lf);
      for (int i = 0; i < N; i++)
         rq[i] = (ms[i] == 2'b01) && !(cxl_valid && cxl_handle == i[1:0]);
      chk(mem_wvalid == ((|rq) && !mem_busy), "R3 wvalid", mem_wvalid, (|rq) && !mem_busy);
      gi = rr_pick(rq);
      fire = (|rq) && !mem_busy && mem_wready;
      if (mem_wvalid && gi >= 0) begin
         chk(mem_waddr == ma[gi], "R4/R6 addr", mem_waddr, ma[gi]);
         chk(mem_wdata == md[gi], "R4/R10 data", mem_wdata, md[gi]);
      end
      if (qry_valid) begin
         chk(qry_status == ms[qry_handle], "R7 status", qry_status, ms[qry_handle]);
         chk(qry_words == mw[qry_handle], "R7 words", qry_words, mw[qry_handle]);
      end
      // model update
      for (int i = 0; i < N; i++) begin
         if (acc && i == lf) begin
            ma[i] = {cmd_addr[31:3], 3'b000};
            md[i] = cmd_data;
            mr[i] = cmd_count;
            mw[i] = 0;
            ms[i] = (cmd_count == 0) ? 2'b10 : 2'b01;
         end else begin
            bit f = fire && (i == gi);
            if (ms[i] == 2'b01 && cxl_valid && cxl_handle == i[1:0]) ms[i] = 2'b11;
            else if (f && mr[i] == 1) ms[i] = 2'b10;
            else if ((ms[i] == 2'b10 || ms[i] == 2'b11) && qry_valid && qry_handle == i[1:0]) ms[i] = 2'b00;
            if (f) begin ma[i] += 8; mr[i] -= 1; mw[i] += 1; end
         end
      end
      if (fire) mlast = gi;
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      cmd_valid = 0; qry_valid = 0; cxl_valid = 0; mem_busy = 0; mem_wready = 0;
   endtask

   initial begin
      int seed = 32'h5eed_0b17;
      void'($urandom(seed));
      for (int i = 0; i < N; i++) begin ms[i] = 0; ma[i] = 0; md[i] = 0; mr[i] = 0; mw[i] = 0; end
      mlast = N - 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      #1;
      chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
      chk(mem_wvalid == 1'b0, "R1 wvalid", mem_wvalid, 0);
      @(negedge clk);
      for (int h = 0; h < N; h++) begin
         idle_inputs(); qry_valid = 1; qry_handle = h[1:0];
         #1 chk(qry_status == 2'b00, "R1 free", qry_status, 0);
         @(negedge clk);
      end
      // R2: fill all buffers while port busy, ready must drop
      for (int h = 0; h < N; h++) begin
         idle_inputs(); mem_busy = 1; cmd_valid = 1;
         cmd_addr = 32'h1000 * (h + 1) + 5; cmd_count = 16'(3 + h); cmd_data = 64'hA0 + 64'(h);
         cycle();
      end
      idle_inputs(); mem_busy = 1; cmd_valid = 1; cmd_count = 2;
      cycle();   // R2: refused, ready low
      // R10: change command bus, then let stores drain (R6 rotation, R4 addresses)
      cmd_addr = 32'hFFFF_FFF8; cmd_data = '1; cmd_valid = 0;
      mem_busy = 0; mem_wready = 1;
      repeat (20) cycle();
      // R5: zero-length command goes straight to done
      for (int h = 0; h < N; h++) begin
         idle_inputs(); qry_valid = 1; qry_handle = h[1:0]; cycle();
      end
      idle_inputs(); cmd_valid = 1; cmd_count = 0; cmd_addr = 32'h40; cycle();
      idle_inputs(); qry_valid = 1; qry_handle = 0; cycle();
      // R9: cancel mid-run, then cancel of a free buffer
      idle_inputs(); cmd_valid = 1; cmd_count = 10; cmd_addr = 32'h2000; cmd_data = 64'h55; cycle();
      idle_inputs(); mem_wready = 1; repeat (2) cycle();
      idle_inputs(); mem_wready = 1; cxl_valid = 1; cxl_handle = 0; cycle();
      idle_inputs(); mem_wready = 1; cxl_valid = 1; cxl_handle = 2; repeat (3) cycle();
      idle_inputs(); qry_valid = 1; qry_handle = 0; cycle();
      // random phase
      for (int n = 0; n < 4000; n++) begin
         cmd_valid  = ($urandom_range(0, 9) < 3);
         cmd_addr   = $urandom();
         cmd_count  = 16'($urandom_range(0, 6));
         cmd_data   = {$urandom(), $urandom()};
         mem_busy   = ($urandom_range(0, 9) < 4);
         mem_wready = ($urandom_range(0, 9) < 7);
         cxl_valid  = ($urandom_range(0, 19) == 0);
         cxl_handle = 2'($urandom_range(0, 3));
         qry_valid  = ($urandom_range(0, 9) < 3);
         qry_handle = 2'($urandom_range(0, 3));
         cycle();
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule